// File: doc/BRIEF.md
# DAC Conversion Trigger Controller

This block decides when a digital-to-analog converter takes a new sample and how long it then waits for the analog output to settle. Software programs it through a small word-addressed register bus. Data written by software is parked in a pending register. It moves to the converter output register only when a valid start event occurs.

There are two start modes. In direct mode, every data write starts a conversion. In triggered mode, exactly one selected source starts conversions. The source can be a self-clearing software bit, an external pin, one of four timer event strobes or one of two PWM event strobes. The external pin passes through a two-flop synchronizer and can act on a low level, a high level, a falling edge or a rising edge.

After each start, a counter runs for the programmed settling time, counted in bus clocks. While the counter runs the block reports busy, and every start event in that time is dropped. When the count expires the block issues a one-cycle done strobe.

Top module: `dac_trig_ctrl`

## Requirements
- R1: After synchronous reset, `dac_out`, `busy`, `done` and every register read as zero.
- R2: With the trigger-enable bit (control bit 4) at 0 and the converter enabled, a write to the data register (word 1) starts a conversion on the clock edge after the write edge.
- R3: `dac_out` changes only on a start event, and then it takes the value held in the pending data register.
- R4: With control bit 4 at 1, data writes do not start a conversion. Only the source chosen by control bits 11:8 starts one. The source codes are: 0 = software bit, 1 = external pin, 2 to 5 = timer events 0 to 3, 6 and 7 = PWM events 0 and 1. Any other code selects nothing. A timer or PWM strobe that is high at a clock edge starts the conversion at that same edge.
- R5: While the converter-enable bit (control bit 0) is 0, no start event is accepted.
- R6: After a start, `busy` stays high for exactly settle+1 clock cycles. Bit 31 of a control register read shows `busy`.
- R7: `done` is high for exactly one cycle, which is the first cycle after `busy` falls.
- R8: A start event that arrives while `busy` is high is ignored. `dac_out` holds its value.
- R9: Data written while busy, or in triggered mode, is kept in the pending register. Reading word 1 returns it.
- R10: Writing 1 to bit 0 of the software-trigger register (word 2) starts a conversion one edge after the write, when that source is selected. The bit clears itself, and a read of word 2 returns 0.
- R11: Control bits 13:12 choose the pin mode: 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge. After a pin change, the start happens on the third clock edge.
- R12: The settling register (word 3) keeps only bits 9:0, so reads return the written value masked to 10 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 control, 1 data, 2 software trigger, 3 settling |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read strobe |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| tmr_evt | input | 4 | Timer event strobes |
| pwm_evt | input | 2 | PWM event strobes |
| dac_out | output | 12 | Converter output register |
| busy | output | 1 | Settling counter running |
| done | output | 1 | One-cycle end-of-settle strobe |

## Verification
The checks assume that timer and PWM strobes, as well as bus accesses, are sampled only on rising edges. They also assume that the external pin has been steady through reset, so the synchronizer does not report an edge that never happened. The bench changes every input on the falling clock edge. It holds the pin low during reset, and its random phase keeps settling counts small so that many conversions overlap with stray triggers and mid-conversion reprogramming.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;
  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_DATA   = 2'd1;
  localparam logic [1:0] REG_SWT    = 2'd2;
  localparam logic [1:0] REG_SETTLE = 2'd3;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_TRG_BIT   = 4;
  localparam int CTRL_SRC_LSB   = 8;
  localparam int CTRL_SRC_W     = 4;
  localparam int CTRL_PMODE_LSB = 12;
  localparam int CTRL_BUSY_BIT  = 31;

  typedef enum logic [1:0] {
    PIN_LOW  = 2'd0,
    PIN_HIGH = 2'd1,
    PIN_FALL = 2'd2,
    PIN_RISE = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic                  conv_en;
    logic                  trig_en;
    logic [CTRL_SRC_W-1:0] src;
    pin_mode_e             pmode;
  } ctrl_t;
endpackage

// File: rtl/dac_trig_regs.sv
module dac_trig_regs
  import dac_trig_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int SETTLE_W = 10,
  parameter int BUS_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [1:0]          bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  input  logic                busy,
  output logic [BUS_W-1:0]    bus_rdata,
  output ctrl_t               ctrl_q,
  output logic [DATA_W-1:0]   pend_q,
  output logic [SETTLE_W-1:0] settle_q,
  output logic                dwr_pulse,
  output logic                sw_pulse
);
  localparam int DPAD = BUS_W - DATA_W;
  localparam int SPAD = BUS_W - SETTLE_W;

  logic wr_en, rd_en;
  logic [BUS_W-1:0] rd_mux;

  assign wr_en = bus_sel & bus_we;
  assign rd_en = bus_sel & ~bus_we;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      REG_CTRL: begin
        rd_mux[CTRL_EN_BIT]  = ctrl_q.conv_en;
        rd_mux[CTRL_TRG_BIT] = ctrl_q.trig_en;
        rd_mux[CTRL_SRC_LSB +: CTRL_SRC_W] = ctrl_q.src;
        rd_mux[CTRL_PMODE_LSB +: 2] = ctrl_q.pmode;
        rd_mux[CTRL_BUSY_BIT] = busy;
      end
      REG_DATA:   rd_mux = {{DPAD{1'b0}}, pend_q};
      REG_SETTLE: rd_mux = {{SPAD{1'b0}}, settle_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      pend_q    <= '0;
      settle_q  <= '0;
      dwr_pulse <= 1'b0;
      sw_pulse  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      dwr_pulse <= 1'b0;
      sw_pulse  <= 1'b0;
      if (wr_en) begin
        case (bus_addr)
          REG_CTRL: begin
            ctrl_q.conv_en <= bus_wdata[CTRL_EN_BIT];
            ctrl_q.trig_en <= bus_wdata[CTRL_TRG_BIT];
            ctrl_q.src     <= bus_wdata[CTRL_SRC_LSB +: CTRL_SRC_W];
            ctrl_q.pmode   <= pin_mode_e'(bus_wdata[CTRL_PMODE_LSB +: 2]);
          end
          REG_DATA: begin
            pend_q    <= bus_wdata[DATA_W-1:0];
            dwr_pulse <= 1'b1;
          end
          REG_SWT:  sw_pulse <= bus_wdata[0];
          default:  settle_q <= bus_wdata[SETTLE_W-1:0];
        endcase
      end
      if (rd_en) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dac_trig_src.sv
module dac_trig_src
  import dac_trig_pkg::*;
#(
  parameter int N_TMR = 4,
  parameter int N_PWM = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ext_pin,
  input  logic [N_TMR-1:0]      tmr_evt,
  input  logic [N_PWM-1:0]      pwm_evt,
  input  logic                  sw_pulse,
  input  logic [CTRL_SRC_W-1:0] src,
  input  pin_mode_e             pmode,
  output logic                  evt
);
  localparam int N_SRC   = 2 + N_TMR + N_PWM;
  localparam int TMR_OFS = 2;
  localparam int PWM_OFS = 2 + N_TMR;

  logic s1, s2, s3;
  logic pin_evt;
  logic [N_SRC-1:0] srcv;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ext_pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_comb begin
    case (pmode)
      PIN_LOW:  pin_evt = ~s2;
      PIN_HIGH: pin_evt = s2;
      PIN_FALL: pin_evt = s3 & ~s2;
      default:  pin_evt = s2 & ~s3;
    endcase
  end

  assign srcv[0] = sw_pulse;
  assign srcv[1] = pin_evt;

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    assign srcv[TMR_OFS + t] = tmr_evt[t];
  end
  for (genvar p = 0; p < N_PWM; p++) begin : g_pwm
    assign srcv[PWM_OFS + p] = pwm_evt[p];
  end

  always_comb begin
    evt = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (src == CTRL_SRC_W'(i)) evt = srcv[i];
    end
  end
endmodule

// File: rtl/dac_settle_timer.sv
module dac_settle_timer #(
  parameter int DATA_W   = 12,
  parameter int SETTLE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle,
  input  logic [DATA_W-1:0]   pend,
  output logic [DATA_W-1:0]   dac_out,
  output logic                busy,
  output logic                done
);
  logic [SETTLE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      dac_out <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        dac_out <= pend;
        busy    <= 1'b1;
        cnt     <= settle;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
  import dac_trig_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int SETTLE_W = 10,
  parameter int BUS_W    = 32,
  parameter int N_TMR    = 4,
  parameter int N_PWM    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ext_pin,
  input  logic [N_TMR-1:0]  tmr_evt,
  input  logic [N_PWM-1:0]  pwm_evt,
  output logic [DATA_W-1:0] dac_out,
  output logic              busy,
  output logic              done
);
  ctrl_t               ctrl_q;
  logic [DATA_W-1:0]   pend_q;
  logic [SETTLE_W-1:0] settle_q;
  logic                dwr_pulse, sw_pulse, evt, start, conv_en_w;

  dac_trig_regs #(.DATA_W(DATA_W), .SETTLE_W(SETTLE_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
    .bus_rdata(bus_rdata), .ctrl_q(ctrl_q), .pend_q(pend_q),
    .settle_q(settle_q), .dwr_pulse(dwr_pulse), .sw_pulse(sw_pulse)
  );

  dac_trig_src #(.N_TMR(N_TMR), .N_PWM(N_PWM)) u_src (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .tmr_evt(tmr_evt),
    .pwm_evt(pwm_evt), .sw_pulse(sw_pulse), .src(ctrl_q.src),
    .pmode(ctrl_q.pmode), .evt(evt)
  );

  assign conv_en_w = ctrl_q.conv_en;
  assign start = conv_en_w & ~busy & (ctrl_q.trig_en ? evt : dwr_pulse);

  dac_settle_timer #(.DATA_W(DATA_W), .SETTLE_W(SETTLE_W)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .settle(settle_q), .pend(pend_q),
    .dac_out(dac_out), .busy(busy), .done(done)
  );
endmodule

// File: rtl/dac_trig_chk.sv
module dac_trig_chk
  import dac_trig_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              conv_en,
  input logic [DATA_W-1:0] dac_out,
  input logic              busy,
  input logic              done
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));

  assert_out_on_start_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_out) |-> $rose(busy));

  assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(dac_out));

  assert_no_start_disabled_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(conv_en));

  assert_swt_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == REG_SWT) |=> (bus_rdata == '0));
endmodule

bind dac_trig_ctrl dac_trig_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .conv_en(conv_en_w),
  .dac_out(dac_out), .busy(busy), .done(done)
);

// File: tb/sim_dac_trig_ctrl.sv
`timescale 1ns/1ps
module sim_dac_trig_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_pin = 1'b0;
  logic [3:0]  tmr_evt = '0;
  logic [1:0]  pwm_evt = '0;
  logic [11:0] dac_out;
  logic        busy, done;

  int n_run = 0, n_fail = 0;
  bit cmp_on = 0, finished = 0;

  always #4 clk = ~clk;

  dac_trig_ctrl u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_pin(ext_pin), .tmr_evt(tmr_evt), .pwm_evt(pwm_evt),
    .dac_out(dac_out), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements
  logic        m_en, m_trg, m_busy, m_done, m_dwr, m_swp, m_s1, m_s2, m_s3;
  logic [3:0]  m_src;
  logic [1:0]  m_pm;
  logic [11:0] m_pend, m_out;
  logic [9:0]  m_settle, m_cnt;

  function automatic logic sel_evt(input logic [3:0] src, input logic [1:0] pm,
                                   input logic s2, input logic s3, input logic swp,
                                   input logic [3:0] te, input logic [1:0] pe);
    logic pin;
    case (pm)
      2'd0: pin = !s2;
      2'd1: pin = s2;
      2'd2: pin = s3 && !s2;
      default: pin = s2 && !s3;
    endcase
    case (src)
      4'd0: return swp;
      4'd1: return pin;
      4'd2, 4'd3, 4'd4, 4'd5: return te[src-4'd2];
      4'd6, 4'd7: return pe[src-4'd6];
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_en, m_trg, m_busy, m_done, m_dwr, m_swp, m_s1, m_s2, m_s3} = '0;
      m_src = '0; m_pm = '0; m_pend = '0; m_out = '0; m_settle = '0; m_cnt = '0;
    end else begin
      logic go;
      go = m_en && !m_busy &&
           (m_trg ? sel_evt(m_src, m_pm, m_s2, m_s3, m_swp, tmr_evt, pwm_evt) : m_dwr);
      m_done = 1'b0;
      if (go) begin
        m_out = m_pend; m_busy = 1'b1; m_cnt = m_settle;
      end else if (m_busy) begin
        if (m_cnt == 0) begin m_busy = 1'b0; m_done = 1'b1; end
        else m_cnt = m_cnt - 1'b1;
      end
      m_dwr = 1'b0; m_swp = 1'b0;
      if (bus_sel && bus_we) begin
        case (bus_addr)
          2'd0: begin
            m_en = bus_wdata[0]; m_trg = bus_wdata[4];
            m_src = bus_wdata[11:8]; m_pm = bus_wdata[13:12];
          end
          2'd1: begin m_pend = bus_wdata[11:0]; m_dwr = 1'b1; end
          2'd2: m_swp = bus_wdata[0];
          default: m_settle = bus_wdata[9:0];
        endcase
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R3 dac_out vs model", {20'd0, dac_out}, {20'd0, m_out});
      chk("R6 busy vs model", {31'd0, busy}, {31'd0, m_busy});
      chk("R7 done vs model", {31'd0, done}, {31'd0, m_done});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int blen;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dac_out reset", {20'd0, dac_out}, 32'd0);
    chk("R1 busy reset", {31'd0, busy}, 32'd0);
    chk("R1 done reset", {31'd0, done}, 32'd0);
    rd(2'd3, r); chk("R1 settle reg reset", r, 32'd0);
    cmp_on = 1;

    // Direct mode: data write starts conversion, settle 3 -> busy 4 cycles
    wr(2'd3, 32'd3);
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h5A5);
    @(negedge clk);
    chk("R2 busy after data write", {31'd0, busy}, 32'd1);
    chk("R3 output takes pending", {20'd0, dac_out}, 32'h5A5);
    blen = 1;
    while (busy && blen < 50) begin @(negedge clk); if (busy) blen++; end
    chk("R6 busy length settle+1", blen, 32'd4);
    chk("R7 done after busy", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk("R7 done single cycle", {31'd0, done}, 32'd0);

    // Settle register masking
    wr(2'd3, 32'h0000FC07);
    rd(2'd3, r); chk("R12 settle masked", r, 32'h007);
    wr(2'd3, 32'd10);

    // Start while busy ignored, pending kept
    wr(2'd1, 32'h111);
    wr(2'd1, 32'h222);
    rd(2'd0, r); chk("R6 busy bit in control read", {31'd0, r[31]}, 32'd1);
    idle(16);
    chk("R8 second write ignored", {20'd0, dac_out}, 32'h111);
    rd(2'd1, r); chk("R9 pending holds later data", r, 32'h222);

    // Triggered mode, timer event 2 (code 4)
    wr(2'd0, 32'h0411);
    wr(2'd1, 32'h333);
    idle(3);
    chk("R4 data write no start in trigger mode", {31'd0, busy}, 32'd0);
    @(negedge clk); tmr_evt = 4'b0010;
    @(negedge clk); tmr_evt = 4'b0000;
    chk("R4 unselected timer no start", {31'd0, busy}, 32'd0);
    @(negedge clk); tmr_evt = 4'b0100;
    @(negedge clk); tmr_evt = 4'b0000;
    chk("R4 selected timer starts", {31'd0, busy}, 32'd1);
    chk("R4 output after timer", {20'd0, dac_out}, 32'h333);
    idle(15);

    // Software trigger
    wr(2'd1, 32'h444);
    wr(2'd0, 32'h0011);
    wr(2'd2, 32'h1);
    @(negedge clk);
    chk("R10 software start", {31'd0, busy}, 32'd1);
    rd(2'd2, r); chk("R10 software bit reads zero", r, 32'd0);
    idle(15);

    // Disabled converter
    wr(2'd0, 32'h0410);
    @(negedge clk); tmr_evt = 4'b0100;
    @(negedge clk); tmr_evt = 4'b0000;
    idle(2);
    chk("R5 no start when disabled", {31'd0, busy}, 32'd0);

    // Pin rising and falling edge
    wr(2'd3, 32'd2);
    wr(2'd1, 32'h555);
    wr(2'd0, 32'h3111);
    idle(4);
    ext_pin = 1'b1;
    idle(2);
    chk("R11 rising not yet", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R11 rising start third edge", {31'd0, busy}, 32'd1);
    idle(6);
    wr(2'd0, 32'h2111);
    idle(2);
    ext_pin = 1'b0;
    idle(2);
    chk("R11 falling not yet", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R11 falling start third edge", {31'd0, busy}, 32'd1);
    idle(6);
    wr(2'd0, 32'h0);
    idle(4);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tmr_evt = ($urandom % 6 == 0) ? 4'($urandom) : 4'd0;
      pwm_evt = ($urandom % 6 == 0) ? 2'($urandom) : 2'd0;
      if ($urandom % 10 == 0) ext_pin = ~ext_pin;
      bus_sel = ($urandom % 5 == 0);
      bus_we = 1'b1;
      bus_addr = 2'($urandom);
      case (bus_addr)
        2'd0: bus_wdata = {18'd0, 2'($urandom), ($urandom % 9 == 0) ? 4'd9 : 4'($urandom % 8),
                           3'd0, 1'($urandom), 3'd0, 1'($urandom % 8 != 0)};
        2'd3: bus_wdata = $urandom % 13;
        default: bus_wdata = $urandom;
      endcase
    end
    @(negedge clk);
    bus_sel = 1'b0; tmr_evt = '0; pwm_evt = '0;
    idle(20);
    finish_run();
  end
endmodule